// File: doc/BRIEF.md
# Multiplexed 8-bit parallel read sequencer

This block is a host-side controller that reads from an asynchronous byte-wide memory or memory-mapped peripheral. The bus it drives shares one byte lane between the low address byte and the returned data. The upper address byte has a lane of its own. A request carries a 16-bit base address. The block puts the address out behind an address latch strobe, releases the shared lane, and then runs a group of four read strobes. It captures the lane as each strobe ends and returns the four bytes together in one response word.

All timing is counted in clock cycles and comes from one 8-bit control word:

| Bit(s) | Field | Effect |
| --- | --- | --- |
| 0 | latch polarity | 1 makes the latch strobe active low; 0 (the reset value) makes it active high |
| 5..1 | strobe width | read-strobe width in cycles, where 0 counts as 1 |
| 6 | hold | adds one hold cycle, H = 1 |
| 7 | flash | adds seven cycles before the first strobe, F = 7 |

The control word can be changed only while the block is idle. A busy flag refuses new requests until the response pulse has been given. The memory side is expected to step its own low address across the group, starting from the latched base.

Top module: `ppr_read_seq`

## Requirements
- R1: After reset, the read strobe is high and the latch strobe is low (inactive under the active-high default). The shared lane is not driven, busy is low and rsp_valid is low.
- R2: A request with req_valid high while busy is low is accepted. Busy is high from the next cycle until the response. A request presented while busy is high starts nothing.
- R3: The latch strobe is active for exactly 2 cycles per group. Control bit 0 selects the polarity: 0 gives active high, 1 gives active low. Bus_ale sits at the inactive level at all other times.
- R4: The low address byte is driven on the shared lane, with bus_ad_oe high, only while the latch strobe is active. The shared lane is never driven while the read strobe is low. The upper address byte stays on its lane for the whole group.
- R5: The first read strobe falls F + H + 1 cycles after the latch strobe ends. F is 7 when control bit 7 is set and 0 otherwise. H is 1 when control bit 6 is set and 0 otherwise.
- R6: Each read strobe stays low for N cycles, where N is the value of control bits 5..1. A value of 0 gives 1 cycle.
- R7: Each latch strobe is followed by exactly four read strobes. Between consecutive strobes the read strobe stays high for H + 1 cycles.
- R8: The shared lane is sampled in the last low cycle of each strobe. The byte from strobe i (i = 0..3) is returned in rsp_data[8i+7:8i].
- R9: rsp_valid is a one-cycle pulse. It comes H + 1 cycles after the fourth strobe rises, and busy is low in the same cycle.
- R10: A control write made while busy is high is ignored. The timing of the current group and of later groups is unchanged.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock; one cycle is the timing unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write enable |
| ctl_wdata | input | 8 | Control word (see the field table above) |
| req_valid | input | 1 | Read request |
| req_addr | input | 16 | Base address of the group |
| busy | output | 1 | Group in progress; requests are refused |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 32 | Four bytes, where strobe i's byte is at bits 8i+7:8i |
| bus_addr_hi | output | 8 | Upper address byte lane |
| bus_ad_out | output | 8 | Low address byte for the shared lane |
| bus_ad_oe | output | 1 | Shared-lane drive enable |
| bus_ad_in | input | 8 | Shared lane as read back |
| bus_ale | output | 1 | Address latch strobe, polarity programmable |
| bus_rd_n | output | 1 | Read strobe, active low |

## Verification
The bench runs the four timing phases at their extremes:
- a strobe-width field of zero, which a careless counter would turn into a zero-width or 32-cycle strobe;
- the largest width of 31;
- flash and hold together, where an off-by-one in the combined setup delay shows as an 8- or 10-cycle gap instead of 9.

The bench memory drives garbage on the lane whenever the strobe is high. A design that samples one cycle late, or puts the bytes in the wrong order, therefore returns wrong data. A request and a control write are injected during a group; a design that honoured either would restart the latch phase, fetch the wrong address or change the next group's timing. The active-low latch mode is checked at idle and during a group, to catch a polarity applied only to the pulse.

// File: rtl/ppr_pkg.sv
package ppr_pkg;
  localparam int LEN_W = 5;
  localparam int CNT_W = LEN_W + 1;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ALE, PH_SETUP, PH_STRB, PH_RECOV
  } phase_t;

  // Control word: bit 7 flash, bit 6 hold, bits 5..1 strobe width, bit 0 latch polarity
  typedef struct packed {
    logic             flash;
    logic             hold;
    logic [LEN_W-1:0] len;
    logic             ale_low;
  } ctl_t;

  // Read-strobe width in cycles; zero is promoted to one
  function automatic logic [CNT_W-1:0] strobe_cycles(input logic [LEN_W-1:0] len);
    return (len == '0) ? CNT_W'(1) : CNT_W'(len);
  endfunction

  // Cycles from latch end to first strobe: F + H + 1
  function automatic logic [CNT_W-1:0] setup_cycles(input logic hold, input logic flash,
                                                    input int flash_cyc);
    return CNT_W'(1) + CNT_W'(hold) + (flash ? CNT_W'(flash_cyc) : CNT_W'(0));
  endfunction

  // Strobe-high recovery between strobes: H + 1
  function automatic logic [CNT_W-1:0] recov_cycles(input logic hold);
    return CNT_W'(1) + CNT_W'(hold);
  endfunction
endpackage

// File: rtl/ppr_ctl_reg.sv
module ppr_ctl_reg
  import ppr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       busy,
  output ctl_t       ctl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ctl <= '0;
    else if (wr && !busy)  ctl <= ctl_t'(wdata);
  end
endmodule

// File: rtl/ppr_fsm.sv
module ppr_fsm
  import ppr_pkg::*;
#(
  parameter int GROUP     = 4,
  parameter int ALE_CYC   = 2,
  parameter int FLASH_CYC = 7,
  localparam int IDX_W    = (GROUP > 1) ? $clog2(GROUP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  ctl_t             ctl,
  output phase_t           phase,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             accept,
  output logic             capture,
  output logic             rsp_valid
);
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;
  logic             group_end;

  assign cnt_zero  = (cnt == '0);
  assign busy      = (phase != PH_IDLE);
  assign accept    = (phase == PH_IDLE) && req_valid;
  assign capture   = (phase == PH_STRB) && cnt_zero;
  assign group_end = (idx == IDX_W'(GROUP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      idx       <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (phase)
        PH_IDLE: if (req_valid) begin
          phase <= PH_ALE;
          cnt   <= CNT_W'(ALE_CYC - 1);
          idx   <= '0;
        end
        PH_ALE: if (cnt_zero) begin
          phase <= PH_SETUP;
          cnt   <= setup_cycles(ctl.hold, ctl.flash, FLASH_CYC) - CNT_W'(1);
        end else cnt <= cnt - CNT_W'(1);
        PH_SETUP: if (cnt_zero) begin
          phase <= PH_STRB;
          cnt   <= strobe_cycles(ctl.len) - CNT_W'(1);
        end else cnt <= cnt - CNT_W'(1);
        PH_STRB: if (cnt_zero) begin
          phase <= PH_RECOV;
          cnt   <= recov_cycles(ctl.hold) - CNT_W'(1);
        end else cnt <= cnt - CNT_W'(1);
        PH_RECOV: if (cnt_zero) begin
          if (group_end) begin
            phase     <= PH_IDLE;
            rsp_valid <= 1'b1;
          end else begin
            idx   <= idx + IDX_W'(1);
            phase <= PH_STRB;
            cnt   <= strobe_cycles(ctl.len) - CNT_W'(1);
          end
        end else cnt <= cnt - CNT_W'(1);
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ppr_pack.sv
module ppr_pack #(
  parameter int GROUP  = 4,
  parameter int BYTE_W = 8,
  localparam int IDX_W = (GROUP > 1) ? $clog2(GROUP) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    capture,
  input  logic [IDX_W-1:0]        idx,
  input  logic [BYTE_W-1:0]       din,
  output logic [GROUP*BYTE_W-1:0] word
);
  for (genvar g = 0; g < GROUP; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               word[g*BYTE_W +: BYTE_W] <= '0;
      else if (capture && idx == IDX_W'(g))     word[g*BYTE_W +: BYTE_W] <= din;
    end
  end
endmodule

// File: rtl/ppr_read_seq.sv
module ppr_read_seq
  import ppr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int GROUP     = 4,
  parameter int ALE_CYC   = 2,
  parameter int FLASH_CYC = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ctl_wr,
  input  logic [7:0]              ctl_wdata,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    busy,
  output logic                    rsp_valid,
  output logic [GROUP*BYTE_W-1:0] rsp_data,
  output logic [ADDR_W-BYTE_W-1:0] bus_addr_hi,
  output logic [BYTE_W-1:0]       bus_ad_out,
  output logic                    bus_ad_oe,
  input  logic [BYTE_W-1:0]       bus_ad_in,
  output logic                    bus_ale,
  output logic                    bus_rd_n
);
  localparam int IDX_W = (GROUP > 1) ? $clog2(GROUP) : 1;

  ctl_t             ctl;
  phase_t           phase;
  logic [IDX_W-1:0] idx;
  logic             evt_accept;
  logic             evt_capture;
  logic             ale_on;
  logic [ADDR_W-1:0] base_q;

  ppr_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata), .busy(busy), .ctl(ctl)
  );

  ppr_fsm #(.GROUP(GROUP), .ALE_CYC(ALE_CYC), .FLASH_CYC(FLASH_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ctl(ctl), .phase(phase),
    .idx(idx), .busy(busy), .accept(evt_accept), .capture(evt_capture),
    .rsp_valid(rsp_valid)
  );

  ppr_pack #(.GROUP(GROUP), .BYTE_W(BYTE_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .capture(evt_capture), .idx(idx), .din(bus_ad_in),
    .word(rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          base_q <= '0;
    else if (evt_accept) base_q <= req_addr;
  end

  assign ale_on      = (phase == PH_ALE);
  assign bus_ale     = ale_on ^ ctl.ale_low;
  assign bus_ad_oe   = ale_on;
  assign bus_ad_out  = base_q[BYTE_W-1:0];
  assign bus_addr_hi = base_q[ADDR_W-1:BYTE_W];
  assign bus_rd_n    = (phase != PH_STRB);
endmodule

// File: rtl/ppr_read_seq_chk.sv
module ppr_read_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       rsp_valid,
  input logic       bus_rd_n,
  input logic       bus_ad_oe,
  input logic       ale_on,
  input logic       accept,
  input logic       capture,
  input logic [7:0] ctl
);
  assert_accept_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy);
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_ale_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale_on) |=> ale_on ##1 !ale_on);
  assert_lane_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_ad_oe);
  assert_no_latch_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !ale_on);
  assert_capture_in_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !bus_rd_n);
  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_rsp_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);
  assert_ctl_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctl));
endmodule

bind ppr_read_seq ppr_read_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rsp_valid(rsp_valid),
  .bus_rd_n(bus_rd_n), .bus_ad_oe(bus_ad_oe), .ale_on(ale_on),
  .accept(evt_accept), .capture(evt_capture), .ctl(ctl)
);

// File: tb/sim_ppr_read_seq.sv
module sim_ppr_read_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        busy, rsp_valid, bus_ad_oe, bus_ale, bus_rd_n;
  logic [31:0] rsp_data;
  logic [7:0]  bus_addr_hi, bus_ad_out, bus_ad_in;

  int total = 0;
  int bad = 0;
  logic [15:0] lat_addr = '0;
  logic [1:0]  rcnt = '0;

  always #2 clk = ~clk;

  ppr_read_seq u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .bus_addr_hi(bus_addr_hi), .bus_ad_out(bus_ad_out),
    .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n)
  );

  function automatic logic [7:0] bmem(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h5A;
  endfunction

  // Memory model: latches the address as the lane is released, steps on each strobe end
  always @(negedge bus_ad_oe) begin lat_addr = {bus_addr_hi, bus_ad_out}; rcnt = 2'd0; end
  always @(posedge bus_rd_n) rcnt = rcnt + 2'd1;
  assign bus_ad_in = bus_rd_n ? 8'hEE : bmem({lat_addr[15:2], lat_addr[1:0] + rcnt});

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [7:0] c);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = c;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic t_reset;
    check(bus_rd_n == 1'b1, "R1", "rd_n", bus_rd_n, 1);
    check(bus_ale == 1'b0, "R1", "ale", bus_ale, 0);
    check(bus_ad_oe == 1'b0, "R1", "oe", bus_ad_oe, 0);
    check(busy == 1'b0, "R1", "busy", busy, 0);
    check(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
  endtask

  // One group with control word c already in place; poke injects a request and a write mid-group
  task automatic t_read(input logic [15:0] a, input logic [7:0] c, input bit poke);
    int n;
    int d, s, r;
    bit oe_bad, hi_bad;
    logic [31:0] exp;
    d = (c[5:1] == 0) ? 1 : int'(c[5:1]);
    s = (c[7] ? 7 : 0) + int'(c[6]) + 1;
    r = int'(c[6]) + 1;
    for (int i = 0; i < 4; i++) exp[8*i +: 8] = bmem({a[15:2], a[1:0] + 2'(i)});
    oe_bad = 0; hi_bad = 0;
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    @(negedge clk); req_valid = 1'b0;
    check(busy == 1'b1, "R2", "busy after accept", busy, 1);
    n = 0;
    while ((bus_ale ^ c[0]) && n < 100) begin
      n++;
      if (!bus_ad_oe || bus_ad_out != a[7:0]) oe_bad = 1;
      if (poke) begin
        req_valid = (n == 1); req_addr = ~a;
        ctl_wr = (n == 1); ctl_wdata = 8'hFE;
      end
      @(negedge clk);
    end
    req_valid = 1'b0; ctl_wr = 1'b0;
    check(n == 2, "R3", "latch width", n, 2);
    check(!oe_bad, "R4", "low address on lane during latch", oe_bad, 0);
    n = 0;
    while (bus_rd_n && n < 100) begin
      n++;
      if (bus_ad_oe || (bus_ale ^ c[0])) oe_bad = 1;
      @(negedge clk);
    end
    check(n == s, "R5", "latch end to strobe", n, s);
    for (int k = 0; k < 4; k++) begin
      n = 0;
      while (!bus_rd_n && n < 100) begin
        n++;
        if (bus_ad_oe) oe_bad = 1;
        if (bus_addr_hi != a[15:8]) hi_bad = 1;
        @(negedge clk);
      end
      check(n == d, "R6", $sformatf("strobe %0d width", k), n, d);
      n = 0;
      while (bus_rd_n && !rsp_valid && n < 100) begin
        n++;
        if (bus_ad_oe || (bus_ale ^ c[0])) oe_bad = 1;
        @(negedge clk);
      end
      if (k < 3) begin
        check(n == r && !rsp_valid, "R7", $sformatf("gap after strobe %0d", k), n, r);
      end else begin
        check(n == r, "R9", "strobe end to response", n, r);
        check(rsp_valid == 1'b1, "R9", "rsp_valid", rsp_valid, 1);
        check(busy == 1'b0, "R9", "busy with response", busy, 0);
        check(rsp_data == exp, "R8", "response bytes", rsp_data, exp);
      end
    end
    check(!oe_bad, "R4", "lane released outside latch", oe_bad, 0);
    check(!hi_bad, "R4", "upper byte held", hi_bad, 0);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9", "pulse one cycle", rsp_valid, 0);
  endtask

  task automatic t_idle_quiet(input int cycles, input logic ale_idle);
    bit moved;
    moved = 0;
    for (int i = 0; i < cycles; i++) begin
      if (busy || !bus_rd_n || bus_ale != ale_idle) moved = 1;
      @(negedge clk);
    end
    check(!moved, "R2", "no group from ignored request", moved, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_read(16'h12C4, 8'h00, 1'b0);
    write_ctl(8'h0A);
    t_read(16'hA57E, 8'h0A, 1'b0);
    write_ctl(8'hC6);
    t_read(16'h3001, 8'hC6, 1'b0);
    write_ctl(8'h46);
    t_read(16'h7F3B, 8'h46, 1'b1);
    t_idle_quiet(12, 1'b0);
    t_read(16'h0BD2, 8'h46, 1'b0);
    write_ctl(8'h3F);
    check(bus_ale == 1'b1, "R3", "active-low latch idles high", bus_ale, 1);
    t_read(16'hFFFF, 8'h3F, 1'b0);
    check(bus_ale == 1'b1, "R3", "active-low latch idles high after group", bus_ale, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule